// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory Controller

This block is the home-node directory for a small group of cache lines. Every coherence request for one of its lines passes through it, so it fixes the order in which cores gain access. Cores send read-shared or read-exclusive requests, each tagged with a core number and a line index. The directory answers with a grant, a negative acknowledgement (retry later), or invalidation messages to other caches. When invalidations are sent, it counts the acknowledgements that come back and issues the grant when the last one arrives.

A full bit vector of holders is not kept for each line. Each line has a few slots that hold binary core numbers, plus an overflow flag. Once the slots are full, the line only remembers that many cores may hold it. A later exclusive request on that line then invalidates every core in the system except the requester. While a line waits for acknowledgements it is marked busy. Any request that reaches a busy line is refused, so only one transition per line is ever in flight.

Top module: `ptrdir_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every line is Invalid, and grant_valid, inv_valid, inv_bcast and every nack bit are 0.
- R2: When several ports request in one cycle, the lowest-numbered valid port is served. Each other valid port gets its nack bit (bit p for port p) set in the next cycle. A lone request is never refused for arbitration.
- R3: A request that targets a line waiting for acknowledgements gets a nack in the next cycle, with no grant. It does not change the line's holders.
- R4: A read-shared request to an Invalid or Shared line is granted in the next cycle (grant_valid=1, grant_excl=0) and records the requester in a free slot. A request from a core already recorded takes no second slot.
- R5: A read-shared request from a new core when all slots are full is granted and sets the line's overflow flag instead of being stored.
- R6: A read-exclusive request to a Shared line without overflow sends one invalidation in the next cycle, with inv_bcast=0. inv_mask bit i is 1 exactly for each recorded core i other than the requester. The grant (grant_excl=1) follows in the cycle after the ack that brings the count to zero.
- R7: A read-exclusive request to an overflowed line sends inv_bcast=1, with inv_mask holding every core except the requester. It needs N_CORES-1 acks before the grant.
- R8: A read-exclusive request to an Invalid line, to a Shared line whose only holder is the requester, or to a line the requester already owns is granted in the next cycle with no invalidation. The line becomes Modified by the requester.
- R9: A request from another core to a Modified line invalidates only the owner and waits for one ack. After the grant, the requester is the sole recorded holder, both for read-shared and for read-exclusive.
- R10: An ack for a line that is not waiting for acknowledgements has no effect.
- R11: In a cycle where an ack completes a transition, the pending requester is granted, and every request presented in that cycle is nacked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_PORTS | Request present, one bit per port |
| req_excl | input | N_PORTS | 1 = read-exclusive, 0 = read-shared, per port |
| req_core | input | N_PORTS*CW | Requesting core number, port p at bits p*CW +: CW |
| req_line | input | N_PORTS*LW | Line index, port p at bits p*LW +: LW |
| ack_valid | input | 1 | One invalidation acknowledgement arrives |
| ack_line | input | LW | Line the acknowledgement belongs to |
| grant_valid | output | 1 | Grant pulse |
| grant_excl | output | 1 | Granted access is exclusive |
| grant_core | output | CW | Core receiving the grant |
| grant_line | output | LW | Line granted |
| nack | output | N_PORTS | Retry response, one bit per port |
| inv_valid | output | 1 | Invalidation message pulse |
| inv_bcast | output | 1 | Invalidation is a broadcast caused by overflow |
| inv_line | output | LW | Line being invalidated |
| inv_mask | output | N_CORES | Cores that must invalidate, bit i = core i |

## Verification
The bench records one core twice and then three more cores, and then asks for exclusive access. If the design spent a slot on the duplicate, the line would overflow and send a broadcast instead of a four-core targeted mask. Overflow is driven by a fifth sharer, and the bench counts fourteen acks that must not grant before the fifteenth that must. A design that miscounted the broadcast would grant early or never. Requests to a busy line, and a request presented in the same cycle that an ack completes a transition, must both be nacked. The first kind would otherwise corrupt the holder list, and the second would collide with the completion grant. The bench also checks same-cycle requests on two ports for lowest-port priority, and a stray ack to an idle line that must not produce a grant.

// File: rtl/ptrdir_pkg.sv
package ptrdir_pkg;
  typedef enum logic [1:0] {
    L_INV = 2'd0,
    L_SHR = 2'd1,
    L_MOD = 2'd2,
    L_BSY = 2'd3
  } line_st_e;
endpackage

// File: rtl/ptrdir_arb.sv
// Fixed priority: lowest index wins.
module ptrdir_arb #(
  parameter int N_PORTS = 2
) (
  input  logic [N_PORTS-1:0] req,
  output logic [N_PORTS-1:0] gnt
);
  logic [N_PORTS:0] seen;
  assign seen[0] = 1'b0;
  for (genvar p = 0; p < N_PORTS; p++) begin : g_pri
    assign gnt[p]    = req[p] & ~seen[p];
    assign seen[p+1] = seen[p] | req[p];
  end
endmodule

// File: rtl/ptrdir_share.sv
// Looks up a requester in a line's pointer slots and builds the target mask.
module ptrdir_share #(
  parameter int N_CORES = 16,
  parameter int N_PTRS  = 4,
  parameter int CW      = 4,
  parameter int PIW     = 2
) (
  input  logic [N_PTRS-1:0][CW-1:0] ptrs,
  input  logic [N_PTRS-1:0]         vld,
  input  logic [CW-1:0]             core,
  output logic                      hit,
  output logic                      full,
  output logic [PIW-1:0]            free_idx,
  output logic [N_CORES-1:0]        tmask,
  output logic [CW:0]               tcnt
);
  logic [N_PTRS-1:0] slot_hit;

  for (genvar s = 0; s < N_PTRS; s++) begin : g_slot
    assign slot_hit[s] = vld[s] && (ptrs[s] == core);
  end

  assign hit  = |slot_hit;
  assign full = &vld;

  always_comb begin
    free_idx = '0;
    for (int s = N_PTRS-1; s >= 0; s--) begin
      if (!vld[s]) free_idx = PIW'(s);
    end
  end

  always_comb begin
    tmask = '0;
    for (int s = 0; s < N_PTRS; s++) begin
      if (vld[s] && !slot_hit[s]) tmask[ptrs[s]] = 1'b1;
    end
  end

  always_comb begin
    tcnt = '0;
    for (int c = 0; c < N_CORES; c++) tcnt = tcnt + (CW+1)'(tmask[c]);
  end
endmodule

// File: rtl/ptrdir_ctrl.sv
module ptrdir_ctrl
  import ptrdir_pkg::*;
#(
  parameter int N_CORES = 16,
  parameter int N_PTRS  = 4,
  parameter int N_LINES = 8,
  parameter int N_PORTS = 2,
  localparam int CW  = $clog2(N_CORES),
  localparam int LW  = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int PW  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int PIW = (N_PTRS > 1) ? $clog2(N_PTRS) : 1,
  localparam int AW  = CW + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_PORTS-1:0]    req_valid,
  input  logic [N_PORTS-1:0]    req_excl,
  input  logic [N_PORTS*CW-1:0] req_core,
  input  logic [N_PORTS*LW-1:0] req_line,
  input  logic                  ack_valid,
  input  logic [LW-1:0]         ack_line,
  output logic                  grant_valid,
  output logic                  grant_excl,
  output logic [CW-1:0]         grant_core,
  output logic [LW-1:0]         grant_line,
  output logic [N_PORTS-1:0]    nack,
  output logic                  inv_valid,
  output logic                  inv_bcast,
  output logic [LW-1:0]         inv_line,
  output logic [N_CORES-1:0]    inv_mask
);
  // Per-line directory table
  line_st_e                  st_q  [N_LINES];
  logic [N_PTRS-1:0][CW-1:0] ptr_q [N_LINES];
  logic [N_PTRS-1:0]         vld_q [N_LINES];
  logic [N_LINES-1:0]        ovf_q;
  logic [CW-1:0]             pc_q  [N_LINES];
  logic [N_LINES-1:0]        pe_q;
  logic [AW-1:0]             cnt_q [N_LINES];

  // Arbitration
  logic [N_PORTS-1:0] gnt;
  logic [PW-1:0]      widx;
  logic               win;
  logic [CW-1:0]      w_core;
  logic [LW-1:0]      w_line;
  logic               w_excl;

  ptrdir_arb #(.N_PORTS(N_PORTS)) u_arb (.req(req_valid), .gnt(gnt));

  always_comb begin
    widx = '0;
    for (int p = N_PORTS-1; p >= 0; p--) begin
      if (gnt[p]) widx = PW'(p);
    end
  end

  assign win    = |req_valid;
  assign w_core = req_core[widx*CW +: CW];
  assign w_line = req_line[widx*LW +: LW];
  assign w_excl = req_excl[widx];

  // Sharer lookup on the winning line
  logic               s_hit, s_full;
  logic [PIW-1:0]     s_free;
  logic [N_CORES-1:0] s_mask;
  logic [AW-1:0]      s_cnt;

  ptrdir_share #(
    .N_CORES(N_CORES), .N_PTRS(N_PTRS), .CW(CW), .PIW(PIW)
  ) u_share (
    .ptrs(ptr_q[w_line]), .vld(vld_q[w_line]), .core(w_core),
    .hit(s_hit), .full(s_full), .free_idx(s_free),
    .tmask(s_mask), .tcnt(s_cnt)
  );

  // Ack handling and request acceptance
  logic a_busy, a_done, take;
  logic [N_CORES-1:0] req_bit, own_bit;

  assign a_busy  = ack_valid && (st_q[ack_line] == L_BSY);
  assign a_done  = a_busy && (cnt_q[ack_line] == AW'(1));
  assign take    = win && !a_done && (st_q[w_line] != L_BSY);
  assign req_bit = N_CORES'(1) << w_core;
  assign own_bit = N_CORES'(1) << ptr_q[w_line][0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_LINES; i++) begin
        st_q[i]  <= L_INV;
        ptr_q[i] <= '0;
        vld_q[i] <= '0;
        pc_q[i]  <= '0;
        cnt_q[i] <= '0;
      end
      ovf_q       <= '0;
      pe_q        <= '0;
      grant_valid <= 1'b0;
      grant_excl  <= 1'b0;
      grant_core  <= '0;
      grant_line  <= '0;
      nack        <= '0;
      inv_valid   <= 1'b0;
      inv_bcast   <= 1'b0;
      inv_line    <= '0;
      inv_mask    <= '0;
    end else begin
      grant_valid <= 1'b0;
      inv_valid   <= 1'b0;
      inv_bcast   <= 1'b0;
      nack        <= req_valid & ~(take ? gnt : '0);

      // Acknowledgement path: completion has priority
      if (a_busy) begin
        if (a_done) begin
          st_q[ack_line]     <= pe_q[ack_line] ? L_MOD : L_SHR;
          ptr_q[ack_line][0] <= pc_q[ack_line];
          vld_q[ack_line]    <= N_PTRS'(1);
          ovf_q[ack_line]    <= 1'b0;
          cnt_q[ack_line]    <= '0;
          grant_valid        <= 1'b1;
          grant_excl         <= pe_q[ack_line];
          grant_core         <= pc_q[ack_line];
          grant_line         <= ack_line;
        end else begin
          cnt_q[ack_line] <= cnt_q[ack_line] - AW'(1);
        end
      end

      // Request path
      if (take) begin
        grant_core <= w_core;
        grant_line <= w_line;
        grant_excl <= w_excl;
        inv_line   <= w_line;
        pc_q[w_line] <= w_core;
        pe_q[w_line] <= w_excl;
        case (st_q[w_line])
          L_INV: begin
            st_q[w_line]     <= w_excl ? L_MOD : L_SHR;
            ptr_q[w_line][0] <= w_core;
            vld_q[w_line]    <= N_PTRS'(1);
            ovf_q[w_line]    <= 1'b0;
            grant_valid      <= 1'b1;
          end
          L_SHR: begin
            if (!w_excl) begin
              grant_valid <= 1'b1;
              if (!s_hit) begin
                if (!s_full) begin
                  ptr_q[w_line][s_free] <= w_core;
                  vld_q[w_line][s_free] <= 1'b1;
                end else begin
                  ovf_q[w_line] <= 1'b1;
                end
              end
            end else if (ovf_q[w_line]) begin
              st_q[w_line]  <= L_BSY;
              cnt_q[w_line] <= AW'(N_CORES-1);
              inv_valid     <= 1'b1;
              inv_bcast     <= 1'b1;
              inv_mask      <= ~req_bit;
            end else if (s_cnt == '0) begin
              st_q[w_line]     <= L_MOD;
              ptr_q[w_line][0] <= w_core;
              vld_q[w_line]    <= N_PTRS'(1);
              grant_valid      <= 1'b1;
            end else begin
              st_q[w_line]  <= L_BSY;
              cnt_q[w_line] <= s_cnt;
              inv_valid     <= 1'b1;
              inv_mask      <= s_mask;
            end
          end
          L_MOD: begin
            if (ptr_q[w_line][0] == w_core) begin
              grant_valid <= 1'b1;
            end else begin
              st_q[w_line]  <= L_BSY;
              cnt_q[w_line] <= AW'(1);
              inv_valid     <= 1'b1;
              inv_mask      <= own_bit;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Assertions
  a_r2_one_served: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(nack) + 1 >= $countones($past(req_valid))));

  a_r7_bcast_width: assert property (@(posedge clk) disable iff (rst)
    inv_bcast |-> (inv_valid && $countones(inv_mask) == N_CORES-1));

  a_r11_no_double: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> !grant_valid);

  a_r6_targets_nonempty: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> (inv_mask != '0));

  for (genvar i = 0; i < N_LINES; i++) begin : g_line_chk
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
      ovf_q[i] |-> (&vld_q[i]));
    a_r3_busy_count: assert property (@(posedge clk) disable iff (rst)
      (st_q[i] == L_BSY) |-> (cnt_q[i] != '0));
  end
endmodule

// File: tb/ptrdir_ctrl_bench.sv
`timescale 1ns/1ps
module ptrdir_ctrl_bench;
  localparam int NC = 16;
  localparam int CW = 4;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    req_valid = '0;
  logic [1:0]    req_excl = '0;
  logic [2*CW-1:0] req_core = '0;
  logic [2*LW-1:0] req_line = '0;
  logic          ack_valid = 1'b0;
  logic [LW-1:0] ack_line = '0;
  logic          grant_valid, grant_excl, inv_valid, inv_bcast;
  logic [CW-1:0] grant_core;
  logic [LW-1:0] grant_line, inv_line;
  logic [1:0]    nack;
  logic [NC-1:0] inv_mask;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ptrdir_ctrl u_ptrdir_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_excl(req_excl),
    .req_core(req_core), .req_line(req_line),
    .ack_valid(ack_valid), .ack_line(ack_line),
    .grant_valid(grant_valid), .grant_excl(grant_excl),
    .grant_core(grant_core), .grant_line(grant_line),
    .nack(nack), .inv_valid(inv_valid), .inv_bcast(inv_bcast),
    .inv_line(inv_line), .inv_mask(inv_mask)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus; outputs sampled at the following negedge.
  task automatic step(bit v0, bit x0, int c0, int l0,
                      bit v1, bit x1, int c1, int l1,
                      bit av, int al);
    @(negedge clk);
    req_valid = {v1, v0};
    req_excl  = {x1, x0};
    req_core  = {CW'(c1), CW'(c0)};
    req_line  = {LW'(l1), LW'(l0)};
    ack_valid = av;
    ack_line  = LW'(al);
    @(negedge clk);
    req_valid = '0;
    ack_valid = 1'b0;
  endtask

  task automatic rq(bit x, int c, int l);
    step(1, x, c, l, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic ack(int l);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, l);
  endtask

  task automatic exp_grant(string tag, int c, int l, bit x);
    chk({tag, " grant_valid"}, grant_valid, 1);
    chk({tag, " grant_core"}, grant_core, c);
    chk({tag, " grant_line"}, grant_line, l);
    chk({tag, " grant_excl"}, grant_excl, x);
    chk({tag, " inv_valid"}, inv_valid, 0);
  endtask

  task automatic exp_inv(string tag, int l, int mask, bit bc);
    chk({tag, " inv_valid"}, inv_valid, 1);
    chk({tag, " inv_line"}, inv_line, l);
    chk({tag, " inv_mask"}, inv_mask, mask);
    chk({tag, " inv_bcast"}, inv_bcast, bc);
    chk({tag, " grant_valid"}, grant_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1 grant idle", grant_valid, 0);
    chk("R1 inv idle", inv_valid, 0);
    chk("R1 bcast idle", inv_bcast, 0);
    chk("R1 nack idle", nack, 0);
    rq(0, 1, 0);
    exp_grant("R1 invalid line grants shared", 1, 0, 0);
  endtask

  task automatic t_dup_targeted();
    rq(0, 2, 1); exp_grant("R4 first sharer", 2, 1, 0);
    rq(0, 2, 1); exp_grant("R4 duplicate sharer", 2, 1, 0);
    rq(0, 3, 1); exp_grant("R4 sharer 3", 3, 1, 0);
    rq(0, 4, 1); exp_grant("R4 sharer 4", 4, 1, 0);
    rq(0, 5, 1); exp_grant("R4 sharer 5 fills slots", 5, 1, 0);
    rq(1, 6, 1); exp_inv("R6 targeted inval", 1, 16'h003C, 0);
    for (int k = 0; k < 3; k++) begin
      ack(1); chk("R6 early ack no grant", grant_valid, 0);
    end
    ack(1); exp_grant("R6 last ack grants", 6, 1, 1);
  endtask

  task automatic t_overflow();
    for (int c = 1; c <= 4; c++) begin
      rq(0, c, 2); exp_grant("R5 fill slot", c, 2, 0);
    end
    rq(0, 5, 2); exp_grant("R5 overflow sharer granted", 5, 2, 0);
    rq(1, 0, 2); exp_inv("R7 broadcast", 2, 16'hFFFE, 1);
    for (int k = 0; k < NC-2; k++) begin
      ack(2); chk("R7 pending ack no grant", grant_valid, 0);
    end
    ack(2); exp_grant("R7 final ack grants", 0, 2, 1);
  endtask

  task automatic t_busy();
    rq(0, 1, 3); exp_grant("R3 setup", 1, 3, 0);
    rq(1, 2, 3); exp_inv("R3 setup inval", 3, 16'h0002, 0);
    rq(0, 4, 3);
    chk("R3 busy nack", nack, 2'b01);
    chk("R3 busy no grant", grant_valid, 0);
    ack(3); exp_grant("R3 transition completes", 2, 3, 1);
    rq(1, 5, 3); exp_inv("R3 refused core not recorded", 3, 16'h0004, 0);
    ack(3); exp_grant("R9 owner invalidated", 5, 3, 1);
  endtask

  task automatic t_arb();
    step(1, 0, 7, 4, 1, 0, 8, 5, 0, 0);
    exp_grant("R2 port0 wins", 7, 4, 0);
    chk("R2 port1 nacked", nack, 2'b10);
    step(0, 0, 0, 0, 1, 0, 8, 5, 0, 0);
    exp_grant("R2 lone port1 served", 8, 5, 0);
    chk("R2 lone no nack", nack, 2'b00);
  endtask

  task automatic t_idle_ack_and_mod();
    ack(6);
    chk("R10 stray ack no grant", grant_valid, 0);
    chk("R10 stray ack no inval", inv_valid, 0);
    rq(1, 9, 6); exp_grant("R8 invalid to modified", 9, 6, 1);
    rq(1, 9, 6); exp_grant("R8 owner re-request", 9, 6, 1);
    rq(0, 3, 7); exp_grant("R8 setup sole sharer", 3, 7, 0);
    rq(1, 3, 7); exp_grant("R8 sole sharer upgrade", 3, 7, 1);
    rq(0, 10, 6); exp_inv("R9 shared on modified", 6, 16'h0200, 0);
    ack(6); exp_grant("R9 shared granted", 10, 6, 0);
    rq(1, 11, 6); exp_inv("R9 requester sole holder", 6, 16'h0400, 0);
    ack(6); exp_grant("R9 exclusive granted", 11, 6, 1);
  endtask

  task automatic t_collide();
    rq(1, 12, 0); exp_inv("R11 setup inval", 0, 16'h0002, 0);
    step(1, 0, 13, 5, 0, 0, 0, 0, 1, 0);
    exp_grant("R11 completion granted", 12, 0, 1);
    chk("R11 request nacked", nack, 2'b01);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_dup_targeted();
    t_overflow();
    t_busy();
    t_arb();
    t_idle_ack_and_mod();
    t_collide();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule